// File: doc/BRIEF.md
# SIMD Unsigned Rounding Average Unit

This block takes two 128-bit vector operands and an element-size code, splits both operands into equal lanes of 8, 16, 32 or 64 bits, and returns the unsigned average of each lane pair, rounded upward. The datapath is one adder of byte-wide slices. Its carry chain is cut at every lane boundary chosen by the size code. A one-bit rounding increment enters at the least significant slice of each lane. Each lane's carry-out is kept, so that after the right shift it becomes the most significant bit of that lane's result.

Operands are presented with a one-cycle `valid` strobe. A small control machine registers the outcome one cycle later. It has three states. ST_IDLE means no request was taken on the last edge. ST_DONE means a legal request was taken, and the registered result is presented with `result_valid`. ST_FAULT means a request with an illegal size code was taken, and `spec_exc` is raised while the result register keeps its previous contents. Every state moves to ST_DONE when `valid` is high with a legal code, to ST_FAULT when `valid` is high with an illegal code, and to ST_IDLE when `valid` is low. Reset places the machine in ST_IDLE and clears the result register.

Top module: `simd_ravg_top`

## Requirements
- R1: The size code `es` selects the lane width N: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64 bits. There are 128/N lanes, and each result lane is (a + b + 1) >> 1 with both operand lanes read as unsigned.
- R2: Lane k occupies bits [127-k*N : 128-(k+1)*N], so lane 0 is at the most significant end. No carry passes from one lane into the next at any width.
- R3: The sum is formed with one bit more than the lane width, and its carry becomes the result MSB. All-ones operands give an all-ones result at every width, including 64-bit lanes.
- R4: When the two operands of a lane differ by one, the result is the larger operand, which means the average is rounded up.
- R5: All-zero operands give an all-zero result.
- R6: A `valid` with a legal code (`es` below 4) produces `result_valid` high for exactly the next cycle, with the new `result` and `spec_exc` low.
- R7: A `valid` with `es` of 4 or above raises `spec_exc` for exactly the next cycle. In that cycle `result_valid` stays low and `result` keeps its previous value.
- R8: A cycle without `valid` leaves both `result_valid` and `spec_exc` low in the following cycle, and `result` unchanged.
- R9: While `rst_n` is low, `result` is zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Request strobe for the operands on this edge |
| es | input | 4 | Element-size code (0..3 legal) |
| a | input | 128 | First operand vector |
| b | input | 128 | Second operand vector |
| result_valid | output | 1 | One-cycle pulse: `result` holds a new average |
| spec_exc | output | 1 | One-cycle pulse: the request had an illegal size code |
| result | output | 128 | Registered lane-wise average |

## Verification
Several operand pairs are applied at more than one width, and the expected value changes with the width. A value of 0x0001_0000 averaged with zero keeps its shape in 16-bit lanes but becomes 0x0000_8000 in 32-bit lanes. This tells a correctly segmented carry chain apart from one cut in the wrong place. Byte patterns whose pairs sum to all ones give 0x80 per byte but 0x8000 per halfword, which separates the lane-top carry handling of the two widths. All-ones, all-zero and differ-by-one operands cover the carry-out MSB, the empty sum and the upward rounding. Distinct values in the two 64-bit lanes show that lane 0 sits at the high end. Illegal codes, idle cycles, back-to-back requests and a reset in mid-run cover the ST_FAULT, ST_IDLE and ST_DONE sequencing.

// File: rtl/simd_ravg_pkg.sv
package simd_ravg_pkg;

    localparam int ES_CODE_W = 4;

    typedef enum logic [1:0] {
        ES_BYTE  = 2'd0,
        ES_HALF  = 2'd1,
        ES_WORD  = 2'd2,
        ES_DWORD = 2'd3
    } elem_sz_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } ravg_state_e;

    // Lane width in bits for a legal size code.
    function automatic int lane_width(elem_sz_e sz);
        int w;
        unique case (sz)
            ES_BYTE:  w = 8;
            ES_HALF:  w = 16;
            ES_WORD:  w = 32;
            ES_DWORD: w = 64;
            default:  w = 8;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/simd_ravg_segctl.sv
// Turns the size code into per-slice lane-boundary masks.
module simd_ravg_segctl
    import simd_ravg_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int SLICE_W = 8
) (
    input  logic [ES_CODE_W-1:0]      es,
    output logic                      es_ok,
    output logic [VEC_W/SLICE_W-1:0]  lane_lo,
    output logic [VEC_W/SLICE_W-1:0]  lane_hi
);

    localparam int NUM_SLICES = VEC_W / SLICE_W;

    int slices_per_lane;

    always_comb begin
        es_ok           = (es[ES_CODE_W-1:2] == '0);
        slices_per_lane = lane_width(elem_sz_e'(es[1:0])) / SLICE_W;
        for (int p = 0; p < NUM_SLICES; p++) begin
            lane_lo[p] = ((p & (slices_per_lane - 1)) == 0);
            lane_hi[p] = ((p & (slices_per_lane - 1)) == (slices_per_lane - 1));
        end
    end

endmodule

// File: rtl/simd_ravg_segadd.sv
// Segmented add with a rounding increment, then a one-bit right shift per lane.
module simd_ravg_segadd #(
    parameter int VEC_W   = 128,
    parameter int SLICE_W = 8
) (
    input  logic [VEC_W-1:0]          a,
    input  logic [VEC_W-1:0]          b,
    input  logic [VEC_W/SLICE_W-1:0]  lane_lo,
    input  logic [VEC_W/SLICE_W-1:0]  lane_hi,
    output logic [VEC_W-1:0]          avg
);

    localparam int NUM_SLICES = VEC_W / SLICE_W;

    logic [VEC_W-1:0]      sum_v;
    logic [NUM_SLICES-1:0] cout_v;
    logic                  carry;
    logic                  cin;
    logic [SLICE_W:0]      part;

    // Ripple across slices; the chain restarts with the rounding one at each lane base.
    always_comb begin
        carry = 1'b0;
        cin   = 1'b0;
        part  = '0;
        for (int p = 0; p < NUM_SLICES; p++) begin
            cin  = lane_lo[p] ? 1'b1 : carry;
            part = {1'b0, a[p*SLICE_W +: SLICE_W]}
                 + {1'b0, b[p*SLICE_W +: SLICE_W]}
                 + {{SLICE_W{1'b0}}, cin};
            sum_v[p*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
            cout_v[p] = part[SLICE_W];
            carry     = part[SLICE_W];
        end
    end

    // Shift right by one; the top bit of each lane takes that lane's carry-out.
    always_comb begin
        avg = {1'b0, sum_v[VEC_W-1:1]};
        for (int p = 0; p < NUM_SLICES; p++) begin
            if (lane_hi[p]) begin
                avg[p*SLICE_W + SLICE_W - 1] = cout_v[p];
            end
        end
    end

endmodule

// File: rtl/simd_ravg_ctrl.sv
// Request state machine and the result register.
module simd_ravg_ctrl
    import simd_ravg_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             es_ok,
    input  logic [VEC_W-1:0] avg,
    output logic             result_valid,
    output logic             spec_exc,
    output logic [VEC_W-1:0] result
);

    ravg_state_e      state_q;
    ravg_state_e      state_d;
    logic [VEC_W-1:0] result_q;

    // Every state follows the same transitions, which depend only on the request.
    always_comb begin
        unique case ({valid, es_ok})
            2'b11:   state_d = ST_DONE;
            2'b10:   state_d = ST_FAULT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_DONE) begin
                result_q <= avg;
            end
        end
    end

    always_comb begin
        result_valid = 1'b0;
        spec_exc     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DONE:  result_valid = 1'b1;
            ST_FAULT: spec_exc     = 1'b1;
            default:  ;
        endcase
    end

    assign result = result_q;

endmodule

// File: rtl/simd_ravg_top.sv
module simd_ravg_top
    import simd_ravg_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int SLICE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic [ES_CODE_W-1:0] es,
    input  logic [VEC_W-1:0]     a,
    input  logic [VEC_W-1:0]     b,
    output logic                 result_valid,
    output logic                 spec_exc,
    output logic [VEC_W-1:0]     result
);

    localparam int NUM_SLICES = VEC_W / SLICE_W;

    logic                  es_ok;
    logic [NUM_SLICES-1:0] lane_lo;
    logic [NUM_SLICES-1:0] lane_hi;
    logic [VEC_W-1:0]      avg;

    simd_ravg_segctl #(
        .VEC_W   (VEC_W),
        .SLICE_W (SLICE_W)
    ) segctl_i (
        .es      (es),
        .es_ok   (es_ok),
        .lane_lo (lane_lo),
        .lane_hi (lane_hi)
    );

    simd_ravg_segadd #(
        .VEC_W   (VEC_W),
        .SLICE_W (SLICE_W)
    ) segadd_i (
        .a       (a),
        .b       (b),
        .lane_lo (lane_lo),
        .lane_hi (lane_hi),
        .avg     (avg)
    );

    simd_ravg_ctrl #(
        .VEC_W (VEC_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid        (valid),
        .es_ok        (es_ok),
        .avg          (avg),
        .result_valid (result_valid),
        .spec_exc     (spec_exc),
        .result       (result)
    );

endmodule

// File: rtl/simd_ravg_chk.sv
module simd_ravg_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid,
    input logic [3:0]       es,
    input logic [VEC_W-1:0] a,
    input logic [VEC_W-1:0] b,
    input logic             result_valid,
    input logic             spec_exc,
    input logic [VEC_W-1:0] result
);

    AST_LEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && es < 4'd4) |=> (result_valid && !spec_exc)); // R6

    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && es >= 4'd4) |=> (spec_exc && !result_valid)); // R7

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        spec_exc |-> $stable(result)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (!result_valid && !spec_exc && $stable(result))); // R8

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(result_valid && spec_exc)); // R6

    AST_ONES_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && es < 4'd4 && a == '1 && b == '1) |=> (result == '1)); // R3

    AST_ZERO_AVG: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && es < 4'd4 && a == '0 && b == '0) |=> (result == '0)); // R5

endmodule

bind simd_ravg_top simd_ravg_chk #(.VEC_W(VEC_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (valid),
    .es           (es),
    .a            (a),
    .b            (b),
    .result_valid (result_valid),
    .spec_exc     (spec_exc),
    .result       (result)
);

// File: tb/simd_ravg_tb_top.sv
`timescale 1ns/1ps
module simd_ravg_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [3:0]   es_i = '0;
    logic [127:0] a_i = '0;
    logic [127:0] b_i = '0;
    logic         result_valid;
    logic         spec_exc;
    logic [127:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    simd_ravg_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid        (valid_i),
        .es           (es_i),
        .a            (a_i),
        .b            (b_i),
        .result_valid (result_valid),
        .spec_exc     (spec_exc),
        .result       (result)
    );

    typedef struct packed {
        logic [3:0]   es;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R1: plain byte lanes
        '{4'd0, {16{8'h01}}, {16{8'h02}}, {16{8'h02}}, 4'd1},
        // R1: pairs summing to all ones, byte width
        '{4'd0, 128'h00112233_44556677_8899AABB_CCDDEEFF,
                128'hFFEEDDCC_BBAA9988_77665544_33221100, {16{8'h80}}, 4'd1},
        // R1: same operands, halfword width
        '{4'd1, 128'h00112233_44556677_8899AABB_CCDDEEFF,
                128'hFFEEDDCC_BBAA9988_77665544_33221100, {8{16'h8000}}, 4'd1},
        // R3: carry-out becomes halfword MSB
        '{4'd1, {8{16'hFFFF}}, {8{16'h0001}}, {8{16'h8000}}, 4'd3},
        // R2: word lane lets upper half shift down
        '{4'd2, {4{32'h0001_0000}}, 128'h0, {4{32'h0000_8000}}, 4'd2},
        // R2: halfword lanes keep the halves apart
        '{4'd1, {4{32'h0001_0000}}, 128'h0, {4{32'h0001_0000}}, 4'd2},
        // R2: doubleword lane
        '{4'd3, {2{64'h0000_0001_0000_0000}}, 128'h0, {2{64'h0000_0000_8000_0000}}, 4'd2},
        // R2: lane 0 is the high half
        '{4'd3, {64'd2, 64'd4}, 128'h0, {64'd1, 64'd2}, 4'd2},
        // R3: word lanes, all ones plus zero
        '{4'd2, {4{32'hFFFF_FFFF}}, 128'h0, {4{32'h8000_0000}}, 4'd3},
        // R4: 64-bit lanes differing by one, 65-bit sum
        '{4'd3, {128{1'b1}}, {2{64'hFFFF_FFFF_FFFF_FFFE}}, {128{1'b1}}, 4'd4},
        // R4: byte lanes differing by one
        '{4'd0, {16{8'h10}}, {16{8'h11}}, {16{8'h11}}, 4'd4},
        // R5: zero operands
        '{4'd3, 128'h0, 128'h0, 128'h0, 4'd5},
        // R3: all ones, byte width
        '{4'd0, {128{1'b1}}, {128{1'b1}}, {128{1'b1}}, 4'd3},
        // R4: word lanes differing by one
        '{4'd2, {4{32'h0000_0007}}, {4{32'h0000_0008}}, {4{32'h0000_0008}}, 4'd4}
    };

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] e, input logic [127:0] x, input logic [127:0] y);
        @(negedge clk);
        es_i    = e;
        a_i     = x;
        b_i     = y;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] prev;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "result in reset", result, 128'h0);
        check("R9", "result_valid in reset", {127'h0, result_valid}, 128'h0);
        check("R9", "spec_exc in reset", {127'h0, spec_exc}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "idle after reset", {126'h0, result_valid, spec_exc}, 128'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            drive(VECS[i].es, VECS[i].a, VECS[i].b);
            check(tag, $sformatf("vector %0d result", i), result, VECS[i].exp);
            check("R6", $sformatf("vector %0d result_valid", i), {127'h0, result_valid}, 128'h1);
            check("R6", $sformatf("vector %0d spec_exc", i), {127'h0, spec_exc}, 128'h0);
            @(negedge clk);
            check("R8", $sformatf("vector %0d pulse ends", i), {127'h0, result_valid}, 128'h0);
            check("R8", $sformatf("vector %0d result held", i), result, VECS[i].exp);
        end

        // R7: illegal size codes leave result alone
        prev = result;
        drive(4'd4, {128{1'b1}}, {128{1'b1}});
        check("R7", "es=4 spec_exc", {127'h0, spec_exc}, 128'h1);
        check("R7", "es=4 result_valid", {127'h0, result_valid}, 128'h0);
        check("R7", "es=4 result unchanged", result, prev);
        drive(4'd15, 128'h1234, 128'h5678);
        check("R7", "es=15 spec_exc", {127'h0, spec_exc}, 128'h1);
        check("R7", "es=15 result unchanged", result, prev);
        @(negedge clk);
        check("R7", "spec_exc pulse ends", {127'h0, spec_exc}, 128'h0);

        // R8: several idle cycles with changing operands
        a_i = {128{1'b1}};
        b_i = 128'h0;
        es_i = 4'd0;
        repeat (3) @(negedge clk);
        check("R8", "idle flags", {126'h0, result_valid, spec_exc}, 128'h0);
        check("R8", "idle result", result, prev);

        // R6: back-to-back requests
        @(negedge clk);
        es_i = 4'd0; a_i = {16{8'h04}}; b_i = {16{8'h06}}; valid_i = 1'b1;
        @(negedge clk);
        check("R6", "first of pair", result, {16{8'h05}});
        es_i = 4'd3; a_i = {64'd9, 64'd0}; b_i = {64'd0, 64'd1};
        @(negedge clk);
        valid_i = 1'b0;
        check("R6", "second of pair", result, {64'd5, 64'd1});
        check("R6", "second pulse", {127'h0, result_valid}, 128'h1);

        // R9: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", "result cleared by reset", result, 128'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule